// File: doc/BRIEF.md
# Separate-Strobe Host Bus Slave

This block lets an external microcontroller reach an internal register file over an asynchronous parallel bus with an active-low chip select, an active-low read strobe and an active-low write strobe. A mode pin picks the address scheme. In multiplexed mode the host places the register address on the shared data lines and pulses an address-latch strobe; the slave keeps that address from the strobe's falling edge onward. In separated mode dedicated address pins carry the address, and both the latch strobe and anything on the data lines during an address phase are ignored.

All bus pins are oversampled by a fast system clock (100 MHz or more) through two-flop synchronizers, and every action is triggered by an edge seen in the synchronized samples. On the inside the block offers a plain register port: address, write data, a one-cycle write enable, a one-cycle read enable and read data. This port has no back-pressure. The write and read enables are single-cycle valids that the register file must accept in that cycle. Read data must be valid, combinationally from the address, during the cycle in which the read enable is high. On the outside the slave drives the data bus through a separate output value and an output enable, which the pad ring combines into a tristate driver.

Top module: `hbus_sep_slave`

## Requirements
- R1: While reset is held and right after it is released, reg_we, reg_re and data_oe are all low.
- R2: With mode_mux = 1, the low AW bits of data_i seen before ale_i falls become reg_addr once the fall has passed the synchronizer, and that address is used for the following read or write.
- R3: With mode_mux = 0, reg_addr follows addr_i while no strobe is low and is frozen for the whole of an access. A pulse on ale_i, and the values on data_i during that pulse, leave reg_addr unchanged.
- R4: Each rising edge of nwr_i inside an access (ncs_i low) gives exactly one reg_we pulse one clock long. The pulse is high at the second falling clock edge after the rise. reg_wdata then holds the data_i value from just before nwr_i rose, even if data_i changes one clock after the rise.
- R5: Each falling edge of nrd_i with ncs_i low gives exactly one reg_re pulse one clock long, high at the second falling clock edge after the strobe fell, with reg_addr valid. One clock later data_oe is high and data_o equals the reg_rdata that was presented during the reg_re cycle.
- R6: data_oe is low whenever ncs_i is high or nrd_i is high. The bus is released as soon as nrd_i rises, without waiting for the synchronizer.
- R7: Strobes on nrd_i or nwr_i while ncs_i is high produce no reg_we, no reg_re and no data_oe.
- R8: In multiplexed mode the latched address persists across accesses until the next falling edge of ale_i. A write followed by a read with no address phase between them both use that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock, at least 100 MHz |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_mux | input | 1 | 1: address from data lines via ale_i; 0: address from addr_i |
| ncs_i | input | 1 | Active-low chip select from the host |
| nrd_i | input | 1 | Active-low read strobe |
| nwr_i | input | 1 | Active-low write strobe |
| ale_i | input | 1 | Address-latch strobe, active high, used in multiplexed mode |
| addr_i | input | AW | Dedicated address pins, used in separated mode |
| data_i | input | DW | Data bus as seen at the pad input |
| data_o | output | DW | Read value driven toward the pad |
| data_oe | output | 1 | Output enable for the data pads |
| reg_addr | output | AW | Register file address |
| reg_wdata | output | DW | Register file write data |
| reg_we | output | 1 | One-cycle write enable |
| reg_re | output | 1 | One-cycle read enable |
| reg_rdata | input | DW | Register file read data, valid in the reg_re cycle |

## Verification
A strobe edge reaches the register port two clock edges after the pin changes, so reg_we or reg_re is expected at the second falling clock edge after the bench drives the edge, and not at the first. data_oe and data_o are expected one falling edge after that. The release of data_oe on nrd_i rising is checked one nanosecond after the pin moves. The bench drives pins on falling clock edges and samples on falling edges, counting edges from each stimulus so that every check lands in the cycle where the result is due, and it counts enable pulses over the whole access to catch duplicates.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  // Bit positions inside the synchronized control vector
  localparam int CTL_W  = 4;
  localparam int C_NCS  = 0;
  localparam int C_NRD  = 1;
  localparam int C_NWR  = 2;
  localparam int C_ALE  = 3;
  // Idle bus: select, read and write deasserted (high), latch strobe low
  localparam logic [CTL_W-1:0] CTL_IDLE = 4'b0111;
  // Flops per synchronizer chain
  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
  parameter int              W      = 1,
  parameter int              STAGES = 2,
  parameter logic [W-1:0]    RST    = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg[i] <= RST;
      end else if (i == 0) begin
        stg[i] <= d;
      end else begin
        stg[i] <= stg[(i == 0) ? 0 : i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hbus_edge.sv
module hbus_edge #(
  parameter int           W   = 1,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur,
  output logic [W-1:0] prev,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= RST;
    else        prev <= cur;
  end

  assign rise = cur & ~prev;
  assign fall = ~cur & prev;
endmodule

// File: rtl/hbus_addr_track.sv
module hbus_addr_track #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mux_mode,
  input  logic          ale_s,
  input  logic          ale_fall,
  input  logic          idle,
  input  logic [AW-1:0] bus_addr,
  input  logic [AW-1:0] pin_addr,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] cand_q;
  logic [AW-1:0] mux_q;
  logic [AW-1:0] sep_q;

  // Multiplexed scheme: keep the newest sample taken while the latch
  // strobe is high, commit it when the strobe's fall is seen.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q <= '0;
      mux_q  <= '0;
    end else if (mux_mode) begin
      if (ale_s)    cand_q <= bus_addr;
      if (ale_fall) mux_q  <= cand_q;
    end
  end

  // Separated scheme: follow the pins while idle, freeze during access.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sep_q <= '0;
    else if (idle) sep_q <= pin_addr;
  end

  assign addr_o = mux_mode ? mux_q : sep_q;
endmodule

// File: rtl/hbus_rd_path.sv
module hbus_rd_path #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_req,
  input  logic [DW-1:0] rd_data_in,
  input  logic          nrd_s,
  input  logic          ncs_s,
  input  logic          nrd_pin,
  input  logic          ncs_pin,
  output logic [DW-1:0] data_o,
  output logic          data_oe
);
  logic [DW-1:0] rd_q;
  logic          oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
      oe_q <= 1'b0;
    end else if (rd_req) begin
      rd_q <= rd_data_in;
      oe_q <= 1'b1;
    end else if (nrd_s || ncs_s) begin
      oe_q <= 1'b0;
    end
  end

  // Raw pins gate the enable so the bus lets go without sync delay.
  assign data_o  = rd_q;
  assign data_oe = oe_q & ~nrd_pin & ~ncs_pin;
endmodule

// File: rtl/hbus_sep_slave.sv
module hbus_sep_slave #(
  parameter int DW = 8,
  parameter int AW = 6   // must not exceed DW (address shares the data lines)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_mux,
  input  logic          ncs_i,
  input  logic          nrd_i,
  input  logic          nwr_i,
  input  logic          ale_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_we,
  output logic          reg_re,
  input  logic [DW-1:0] reg_rdata
);
  import hbus_pkg::*;

  logic [CTL_W-1:0] ctl_raw, ctl_s, ctl_p, ctl_rise, ctl_fall;
  logic [DW-1:0]    data_s;
  logic [AW-1:0]    addr_s;
  logic [DW-1:0]    wlatch_q;

  assign ctl_raw = {ale_i, nwr_i, nrd_i, ncs_i};

  hbus_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST(CTL_IDLE)) u_sync_ctl (
    .clk(clk), .rst_n(rst_n), .d(ctl_raw), .q(ctl_s));

  hbus_sync #(.W(DW), .STAGES(SYNC_STAGES), .RST('0)) u_sync_data (
    .clk(clk), .rst_n(rst_n), .d(data_i), .q(data_s));

  hbus_sync #(.W(AW), .STAGES(SYNC_STAGES), .RST('0)) u_sync_addr (
    .clk(clk), .rst_n(rst_n), .d(addr_i), .q(addr_s));

  hbus_edge #(.W(CTL_W), .RST(CTL_IDLE)) u_edge (
    .clk(clk), .rst_n(rst_n), .cur(ctl_s), .prev(ctl_p),
    .rise(ctl_rise), .fall(ctl_fall));

  // Read request on the read strobe's fall; select was low by then.
  assign reg_re = ctl_fall[C_NRD] & ~ctl_s[C_NCS] & ctl_s[C_NWR];
  // Write pulse on the write strobe's rise; judge select from the
  // last sample with the strobe still low, since both may rise together.
  assign reg_we = ctl_rise[C_NWR] & ~ctl_p[C_NCS] & ctl_p[C_NRD];

  // Track host data while the write strobe is low; the value held at
  // the rise is the last one sampled before it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wlatch_q <= '0;
    else if (!ctl_s[C_NWR] && !ctl_s[C_NCS]) wlatch_q <= data_s;
  end
  assign reg_wdata = wlatch_q;

  hbus_addr_track #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .mux_mode(mode_mux),
    .ale_s(ctl_s[C_ALE]), .ale_fall(ctl_fall[C_ALE]),
    .idle(ctl_s[C_NRD] & ctl_s[C_NWR]),
    .bus_addr(data_s[AW-1:0]), .pin_addr(addr_s), .addr_o(reg_addr));

  hbus_rd_path #(.DW(DW)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_req(reg_re), .rd_data_in(reg_rdata),
    .nrd_s(ctl_s[C_NRD]), .ncs_s(ctl_s[C_NCS]),
    .nrd_pin(nrd_i), .ncs_pin(ncs_i),
    .data_o(data_o), .data_oe(data_oe));
endmodule

// File: rtl/hbus_sep_slave_chk.sv
module hbus_sep_slave_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ncs_i,
  input logic          nrd_i,
  input logic          data_oe,
  input logic          reg_we,
  input logic          reg_re,
  input logic [AW-1:0] reg_addr
);
  // R6: bus never driven with select or read strobe high
  a_r6_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
    (ncs_i || nrd_i) |-> !data_oe);

  // R4: write enable lasts one clock
  a_r4_we_single: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  // R5: read enable lasts one clock
  a_r5_re_single: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> !reg_re);

  // R5: output enable only turns on right after a read request
  a_r5_oe_after_re: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_oe) |-> $past(reg_re));

  // R7: select held high means no register traffic
  a_r7_ncs_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (ncs_i && $past(ncs_i) && $past(ncs_i, 2) && $past(ncs_i, 3))
      |-> (!reg_we && !reg_re));

  // R3: address frozen across the read request
  a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> $stable(reg_addr));
endmodule

bind hbus_sep_slave hbus_sep_slave_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ncs_i(ncs_i), .nrd_i(nrd_i),
  .data_oe(data_oe), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr));

// File: tb/hbus_sep_slave_tb_top.sv
module hbus_sep_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_mux = 1'b0;
  logic          ncs_i = 1'b1, nrd_i = 1'b1, nwr_i = 1'b1, ale_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] data_i = '0;
  logic [DW-1:0] data_o;
  logic          data_oe;
  logic [AW-1:0] reg_addr;
  logic [DW-1:0] reg_wdata;
  logic          reg_we, reg_re;
  logic [DW-1:0] reg_rdata;

  int n_tests = 0;
  int n_fail  = 0;
  int we_cnt = 0, re_cnt = 0;
  logic [AW-1:0] we_addr;
  logic [DW-1:0] we_data;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Register file model: read value is a fixed function of the address
  assign reg_rdata = 8'h5A ^ {2'b00, reg_addr};

  hbus_sep_slave #(.DW(DW), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_mux(mode_mux), .ncs_i(ncs_i),
    .nrd_i(nrd_i), .nwr_i(nwr_i), .ale_i(ale_i), .addr_i(addr_i),
    .data_i(data_i), .data_o(data_o), .data_oe(data_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_re(reg_re), .reg_rdata(reg_rdata));

  always @(negedge clk) begin
    if (rst_n && reg_we) begin
      we_cnt++;
      we_addr = reg_addr;
      we_data = reg_wdata;
    end
    if (rst_n && reg_re) re_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic set_addr(input logic mux, input logic [AW-1:0] a);
    mode_mux = mux;
    if (mux) begin
      data_i = {2'b00, a};
    end else begin
      addr_i = a;
      data_i = 8'h3F ^ {2'b00, a};
    end
    ale_i = 1'b1;
    repeat (3) @(negedge clk);
    ale_i = 1'b0;
    repeat (2) @(negedge clk);
    data_i = 8'hFF;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_write(input logic [DW-1:0] d);
    ncs_i = 1'b0;
    @(negedge clk);
    data_i = d;
    nwr_i  = 1'b0;
    repeat (8) @(negedge clk);
    nwr_i = 1'b1;
    @(negedge clk);
    chk(reg_we == 1'b0, "R4 no write pulse one edge after rise", reg_we, 0);
    data_i = ~d;
    @(negedge clk);
    chk(reg_we == 1'b1, "R4 write pulse two edges after rise", reg_we, 1);
    chk(reg_wdata == d, "R4 write data before rise", reg_wdata, d);
    repeat (4) @(negedge clk);
    ncs_i = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input string req);
    int c0 = re_cnt;
    logic [DW-1:0] exp = 8'h5A ^ {2'b00, a};
    ncs_i = 1'b0;
    @(negedge clk);
    nrd_i = 1'b0;
    @(negedge clk);
    chk(reg_re == 1'b0 && data_oe == 1'b0, "R5 nothing one edge after fall",
        {reg_re, data_oe}, 0);
    @(negedge clk);
    chk(reg_re == 1'b1, "R5 read pulse two edges after fall", reg_re, 1);
    chk(reg_addr == a, req, reg_addr, a);
    @(negedge clk);
    chk(data_oe == 1'b1, "R5 output enable one edge after pulse", data_oe, 1);
    chk(data_o == exp, "R5 read data", data_o, exp);
    repeat (5) @(negedge clk);
    nrd_i = 1'b1;
    #1;
    chk(data_oe == 1'b0, "R6 release on read strobe rise", data_oe, 0);
    @(negedge clk);
    ncs_i = 1'b1;
    repeat (12) @(negedge clk);
    chk(re_cnt == c0 + 1, "R5 one read pulse per access", re_cnt, c0 + 1);
  endtask

  task automatic t_reset();
    chk(reg_we == 0 && reg_re == 0 && data_oe == 0, "R1 outputs low in reset",
        {reg_we, reg_re, data_oe}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(reg_we == 0 && reg_re == 0 && data_oe == 0, "R1 outputs low after reset",
        {reg_we, reg_re, data_oe}, 0);
  endtask

  task automatic t_write(input logic mux, input logic [AW-1:0] a, input logic [DW-1:0] d);
    int c0 = we_cnt;
    set_addr(mux, a);
    do_write(d);
    chk(we_cnt == c0 + 1, "R4 one write pulse per access", we_cnt, c0 + 1);
    chk(we_addr == a, mux ? "R2 write address from data lines" :
        "R3 write address from pins", we_addr, a);
  endtask

  task automatic t_read(input logic mux, input logic [AW-1:0] a);
    set_addr(mux, a);
    do_read(a, mux ? "R2 read address from data lines" : "R3 read address from pins");
  endtask

  task automatic t_ncs_high();
    int w0 = we_cnt;
    int r0 = re_cnt;
    bit oe_seen = 0;
    ncs_i = 1'b1;
    data_i = 8'h77;
    nwr_i = 1'b0;
    repeat (8) @(negedge clk);
    nwr_i = 1'b1;
    repeat (10) @(negedge clk);
    nrd_i = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (data_oe) oe_seen = 1;
    end
    nrd_i = 1'b1;
    repeat (10) @(negedge clk);
    chk(we_cnt == w0, "R7 no write with select high", we_cnt, w0);
    chk(re_cnt == r0, "R7 no read with select high", re_cnt, r0);
    chk(!oe_seen, "R7 no drive with select high", oe_seen, 0);
  endtask

  task automatic t_sep_ale_ignored();
    mode_mux = 1'b0;
    addr_i = 6'h05;
    repeat (5) @(negedge clk);
    data_i = 8'h2A;
    ale_i = 1'b1;
    repeat (3) @(negedge clk);
    ale_i = 1'b0;
    repeat (6) @(negedge clk);
    chk(reg_addr == 6'h05, "R3 latch strobe ignored in separated mode", reg_addr, 6'h05);
  endtask

  task automatic t_mux_persist();
    int c0 = we_cnt;
    set_addr(1'b1, 6'h11);
    do_write(8'h3C);
    chk(we_cnt == c0 + 1 && we_addr == 6'h11, "R8 write uses latched address",
        we_addr, 6'h11);
    data_i = 8'h0F;
    repeat (3) @(negedge clk);
    do_read(6'h11, "R8 address kept for next access");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    t_write(1'b1, 6'h2B, 8'hC3);
    t_write(1'b0, 6'h1D, 8'h96);
    t_read(1'b1, 6'h07);
    t_read(1'b0, 6'h3E);
    t_ncs_high();
    t_sep_ale_ignored();
    t_mux_persist();
    t_write(1'b0, 6'h00, 8'h00);
    t_read(1'b1, 6'h3F);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule